// File: doc/BRIEF.md
# Read-Triggered Serial Master Receiver

This block is a receive-only clocked serial master. It drives a serial clock derived from the system clock and samples one serial data input into a shift register. Software controls it through three word-wide registers on a simple read/write bus: a control word, a status word and a receive data word. No transmit data exists. Instead, software starts each frame by reading the receive data word. The first such read returns a value that carries no meaning, and every later read returns the word from the frame that just finished.

Frames run back to back while the scan-enable bit stays set. A read issued during a frame arms the next frame, which then starts in the cycle after completion. Clearing scan-enable lets the current frame finish and stops any further frames. The busy flag tells software when power can safely be removed. A sticky overrun flag records any word that was overwritten before it was read.

Register map (word addresses): 0 = control, 1 = status, 2 = receive data (read only). Control bits: [0] power, [1] receive-enable, [2] scan-enable, [3] bit order (0 = MSB first, 1 = LSB first), [4] clock idle level, [5] sample phase, [11:8] length code. The other control bits are stored and read back with no effect. Status bits: [0] busy, [1] overrun.

Top module: `rdtrig_rx_master`

## Requirements
- R1: While control bit 0 (power) is 0, the busy flag stays 0, the serial clock does not toggle and no interrupt is raised. Clearing power during a frame drops busy by the second cycle after the write, returns the clock to its idle level and raises no interrupt.
- R2: A read of address 2 starts a frame only when power, receive-enable (bit 1) and scan-enable (bit 2) are all set and no frame is running. Status bit 0 reads 1 in the cycle after the read, and that read returns the earlier receive content (0 after reset).
- R3: When a frame ends, the received word is loaded into the receive register, right-aligned and zero-extended, and `done_irq` is high for exactly one cycle.
- R4: Control bit 3 = 0 takes the first received bit as the most significant bit of the word. Bit 3 = 1 takes it as the least significant bit.
- R5: The serial clock idles at the level of control bit 4. Each half period lasts DIV_N system clocks. With bit 5 = 0 data is sampled on the odd-numbered (leading) clock edges of a frame, and with bit 5 = 1 on the even-numbered (trailing) edges.
- R6: Length code c in control bits [11:8] gives min(8 + c, MAX_BITS) bits per frame, so code 0 gives 8 bits and codes above the cap are clamped.
- R7: After scan-enable is cleared, a frame already running completes with its interrupt, and later reads of address 2 start nothing.
- R8: Status bit 0 (busy) is 1 from the cycle after the start until the frame's final clock edge, and 0 afterwards when no next frame is armed.
- R9: If a frame completes while the previous word has not been read, the receive register is overwritten and status bit 1 is set. Bit 1 holds until a write to address 1 with bit 1 set clears it.
- R10: With scan-enable set, a read of address 2 after completion returns the completed word and starts the next frame at once. A read during a frame arms a follow-on frame that starts right after completion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 2 | Register word address |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (a read of address 2 is the frame trigger) |
| bus_wdata | input | REG_W | Write data |
| bus_rdata | output | REG_W | Read data, valid in the cycle of the strobe |
| sclk_o | output | 1 | Serial clock to the slave |
| sdi_i | input | 1 | Serial data from the slave |
| done_irq | output | 1 | One-cycle frame completion pulse |

## Verification
The overrun flag is the hardest state to reach from the ports. Every frame start needs a read, and that read also consumes the pending word, so a plain trigger-and-wait sequence can never overwrite unread data. The bench therefore issues a second receive read while the first frame is still shifting. This arms a follow-on frame that starts without a read in between. The bench then lets that frame finish unread, and a slave model serves both words back to back. It checks that the status shows the overrun, that the later word replaced the earlier one, and that the write-one-to-clear takes effect.

// File: rtl/rdtrig_rx_master.sv
module rdtrig_rx_master #(
  parameter int REG_W    = 16,
  parameter int MAX_BITS = 16,
  parameter int DIV_N    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       bus_addr,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [REG_W-1:0] bus_wdata,
  output logic [REG_W-1:0] bus_rdata,
  output logic             sclk_o,
  input  logic             sdi_i,
  output logic             done_irq
);

  localparam int CNT_W  = (DIV_N > 1) ? $clog2(DIV_N) : 1;
  localparam int LEN_W  = $clog2(MAX_BITS + 24);
  localparam int HALF_W = LEN_W + 1;
  localparam logic [1:0] A_CTL = 2'd0, A_STAT = 2'd1, A_RX = 2'd2;

  logic [REG_W-1:0]    ctl_q, rx_q;
  logic                busy, pend, unread, ovr, sclk_q, done_q;
  logic [CNT_W-1:0]    cnt;
  logic [HALF_W-1:0]   half, last_half;
  logic [MAX_BITS-1:0] sh, sh_next, mask, top_bit;
  logic [MAX_BITS:0]   one_sh;
  logic [LEN_W-1:0]    want, nbits;

  wire ctl_pwr  = ctl_q[0];
  wire ctl_rxen = ctl_q[1];
  wire ctl_scan = ctl_q[2];
  wire ctl_lsb  = ctl_q[3];
  wire ctl_cpol = ctl_q[4];
  wire ctl_cpha = ctl_q[5];
  wire [3:0] ctl_len = ctl_q[11:8];

  assign want      = LEN_W'(8) + LEN_W'(ctl_len);
  assign nbits     = (want > LEN_W'(MAX_BITS)) ? LEN_W'(MAX_BITS) : want;
  assign last_half = {nbits, 1'b0} - HALF_W'(1);
  assign one_sh    = (MAX_BITS+1)'(1) << nbits;
  assign mask      = one_sh[MAX_BITS-1:0] - MAX_BITS'(1);
  assign top_bit   = mask ^ (mask >> 1);

  wire rd_rx     = bus_rd && bus_addr == A_RX;
  wire wr_ctl    = bus_wr && bus_addr == A_CTL;
  wire wr_stat   = bus_wr && bus_addr == A_STAT;
  wire can_run   = ctl_pwr && ctl_rxen && ctl_scan;
  wire half_end  = busy && cnt == CNT_W'(DIV_N - 1);
  wire sample    = half_end && (half[0] == ctl_cpha);
  wire frame_end = half_end && half == last_half;
  wire start     = !busy && rd_rx && can_run;
  wire arm       = pend || (rd_rx && ctl_scan);
  wire chain     = frame_end && arm && can_run;

  always_comb begin
    sh_next = sh;
    if (sample) begin
      if (ctl_lsb) sh_next = (sh >> 1) | (sdi_i ? top_bit : '0);
      else         sh_next = {sh[MAX_BITS-2:0], sdi_i};
    end
  end

  always_comb begin
    case (bus_addr)
      A_CTL:   bus_rdata = ctl_q;
      A_STAT:  bus_rdata = REG_W'({ovr, busy});
      A_RX:    bus_rdata = rx_q;
      default: bus_rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q <= '0; rx_q <= '0; busy <= 1'b0; pend <= 1'b0; unread <= 1'b0;
      ovr <= 1'b0; sclk_q <= 1'b0; done_q <= 1'b0; cnt <= '0; half <= '0; sh <= '0;
    end else begin
      done_q <= 1'b0;
      if (wr_ctl) ctl_q <= bus_wdata;

      if (frame_end && unread && !rd_rx) ovr <= 1'b1;
      else if (wr_stat && bus_wdata[1])  ovr <= 1'b0;

      if (frame_end)  unread <= 1'b1;
      else if (rd_rx) unread <= 1'b0;

      if (!ctl_pwr) begin
        busy <= 1'b0; pend <= 1'b0; sclk_q <= ctl_cpol; cnt <= '0; half <= '0;
      end else if (start) begin
        busy <= 1'b1; pend <= 1'b0; cnt <= '0; half <= '0; sh <= '0;
      end else if (busy) begin
        cnt <= half_end ? '0 : cnt + CNT_W'(1);
        sh  <= sh_next;
        if (half_end) begin
          sclk_q <= ~sclk_q;
          half   <= half + HALF_W'(1);
        end
        if (rd_rx && ctl_scan) pend <= 1'b1;
        if (frame_end) begin
          rx_q   <= REG_W'(sh_next & mask);
          done_q <= 1'b1;
          pend   <= 1'b0;
          if (chain) begin
            half <= '0; sh <= '0;
          end else begin
            busy <= 1'b0;
          end
        end
      end else begin
        sclk_q <= ctl_cpol;
      end
    end
  end

  assign sclk_o   = sclk_q;
  assign done_irq = done_q;

  AST_UNPOWERED_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !ctl_pwr |=> (!busy && !done_irq)); // R1
  AST_START_BY_READ:  assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> $past(rd_rx)); // R2
  AST_IRQ_SINGLE:     assert property (@(posedge clk) disable iff (!rst_n) done_irq |=> !done_irq); // R3
  AST_IDLE_LEVEL:     assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> sclk_o == ctl_cpol); // R5
  AST_NO_START_SCANOFF: assert property (@(posedge clk) disable iff (!rst_n) (!busy && !ctl_scan) |=> !busy); // R7
  AST_OVR_HOLD:       assert property (@(posedge clk) disable iff (!rst_n) (ovr && !(wr_stat && bus_wdata[1])) |=> ovr); // R9

endmodule

// File: tb/tb_rdtrig_rx_master.sv
module tb_rdtrig_rx_master;
  localparam int DIV = 4;
  localparam logic [1:0] A_CTL = 2'd0, A_STAT = 2'd1, A_RX = 2'd2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic bus_wr = 1'b0, bus_rd = 1'b0, sdi_i = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic sclk_o, done_irq;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  rdtrig_rx_master #(.REG_W(16), .MAX_BITS(16), .DIV_N(DIV)) dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sclk_o(sclk_o), .sdi_i(sdi_i),
    .done_irq(done_irq));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] ctl(input bit pwr, input bit rxen, input bit scan,
                                      input bit lsb, input bit cpol, input bit cpha,
                                      input logic [3:0] len);
    return {4'h0, len, 2'b00, cpha, cpol, lsb, scan, rxen, pwr};
  endfunction

  function automatic logic bit_of(input logic [15:0] w, input int nb, input bit lsb, input int i);
    return lsb ? w[i] : w[nb-1-i];
  endfunction

  task automatic bus_write(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  // slave model: presents bits half a period ahead of the sampling edge
  task automatic serve(input logic [15:0] w, input int nb, input bit lsb, input bit cpha);
    int edges = 0, gap = 0;
    bit gap_bad = 0;
    logic prev = sclk_o;
    sdi_i = bit_of(w, nb, lsb, 0);
    while (edges < 2*nb) begin
      @(negedge clk); gap++;
      if (sclk_o !== prev) begin
        prev = sclk_o; edges++;
        if (edges > 1 && gap != DIV) gap_bad = 1;
        gap = 0;
        if (!cpha && edges % 2 == 0 && edges/2 < nb) sdi_i = bit_of(w, nb, lsb, edges/2);
        if (cpha && edges % 2 == 1) sdi_i = bit_of(w, nb, lsb, (edges-1)/2);
      end
    end
    chk("R5 half period", 32'(gap_bad), 32'd0);
  endtask

  task automatic quiet(input int n, input string req);
    int tog = 0, irq = 0;
    logic prev = sclk_o;
    repeat (n) begin
      @(negedge clk);
      if (sclk_o !== prev) tog++;
      if (done_irq) irq++;
      prev = sclk_o;
    end
    chk({req, " clock toggles"}, 32'(tog), 32'd0);
    chk({req, " interrupts"}, 32'(irq), 32'd0);
  endtask

  task automatic t_reset();
    logic [15:0] d;
    chk("R1 reset sclk", 32'(sclk_o), 32'd0);
    chk("R3 reset irq", 32'(done_irq), 32'd0);
    bus_read(A_STAT, d); chk("R8 reset status", 32'(d), 32'd0);
    bus_read(A_RX, d);   chk("R2 reset rx", 32'(d), 32'd0);
    bus_read(A_CTL, d);  chk("R1 reset ctl", 32'(d), 32'd0);
  endtask

  task automatic t_unpowered();
    logic [15:0] d;
    bus_write(A_CTL, ctl(0, 1, 1, 0, 0, 0, 4'd0));
    bus_read(A_RX, d);
    bus_read(A_STAT, d); chk("R1 no busy unpowered", 32'(d[0]), 32'd0);
    quiet(40, "R1 unpowered");
  endtask

  task automatic t_no_rxen();
    logic [15:0] d;
    bus_write(A_CTL, ctl(1, 0, 1, 0, 0, 0, 4'd0));
    bus_read(A_RX, d);
    bus_read(A_STAT, d); chk("R2 no start without rx enable", 32'(d[0]), 32'd0);
    quiet(40, "R2 rx disabled");
  endtask

  task automatic t_msb_continuous();
    logic [15:0] d, s;
    bus_write(A_CTL, ctl(1, 1, 1, 0, 0, 0, 4'd0));
    fork
      serve(16'hA5, 8, 0, 0);
      bus_read(A_RX, d);
    join
    chk("R2 dummy read value", 32'(d), 32'd0);
    chk("R3 irq at completion", 32'(done_irq), 32'd1);
    @(negedge clk);
    chk("R3 irq one cycle", 32'(done_irq), 32'd0);
    fork
      serve(16'h3C, 8, 0, 0);
      begin bus_read(A_RX, d); bus_read(A_STAT, s); end
    join
    chk("R10 read returns completed word", 32'(d), 32'hA5);
    chk("R8 busy during frame", 32'(s[0]), 32'd1);
    bus_read(A_STAT, s);
    chk("R8 busy clear after frame", 32'(s[0]), 32'd0);
    fork
      serve(16'h5A, 8, 0, 0);
      bus_read(A_RX, d);
    join
    chk("R10 second continuous word", 32'(d), 32'h3C);
    bus_write(A_CTL, ctl(1, 1, 0, 0, 0, 0, 4'd0));
    bus_read(A_RX, d);
    chk("R4 MSB first 8-bit word", 32'(d), 32'h5A);
  endtask

  task automatic one_shot(input logic [15:0] cfg, input logic [15:0] w, input int nb,
                          input string req);
    logic [15:0] d;
    bus_write(A_CTL, cfg | 16'h0007);
    repeat (2) @(negedge clk);
    chk({req, " idle level"}, 32'(sclk_o), 32'(cfg[4]));
    fork
      serve(w, nb, cfg[3], cfg[5]);
      bus_read(A_RX, d);
    join
    chk({req, " irq"}, 32'(done_irq), 32'd1);
    bus_write(A_CTL, (cfg | 16'h0003) & ~16'h0004);
    bus_read(A_RX, d);
    chk({req, " word"}, 32'(d), 32'(w));
    chk({req, " idle level after"}, 32'(sclk_o), 32'(cfg[4]));
  endtask

  task automatic t_scan_end();
    logic [15:0] d;
    bus_write(A_CTL, ctl(1, 1, 1, 0, 0, 0, 4'd0));
    fork
      serve(16'h77, 8, 0, 0);
      begin
        bus_read(A_RX, d);
        repeat (8) @(negedge clk);
        bus_write(A_CTL, ctl(1, 1, 0, 0, 0, 0, 4'd0));
      end
    join
    chk("R7 running frame completes", 32'(done_irq), 32'd1);
    bus_read(A_RX, d);
    chk("R7 completed word", 32'(d), 32'h77);
    bus_read(A_RX, d);
    bus_read(A_STAT, d);
    chk("R7 no start after scan end", 32'(d[0]), 32'd0);
    quiet(50, "R7 after scan end");
  endtask

  task automatic t_overrun();
    logic [15:0] d;
    bus_write(A_CTL, ctl(1, 1, 1, 0, 0, 0, 4'd0));
    fork
      begin serve(16'hC3, 8, 0, 0); serve(16'h96, 8, 0, 0); end
      begin
        bus_read(A_RX, d);
        repeat (10) @(negedge clk);
        bus_read(A_RX, d);
      end
    join
    bus_read(A_STAT, d);
    chk("R9 overrun set", 32'(d[1]), 32'd1);
    chk("R10 armed chain ended", 32'(d[0]), 32'd0);
    bus_write(A_STAT, 16'h0000);
    bus_read(A_STAT, d);
    chk("R9 overrun sticky", 32'(d[1]), 32'd1);
    bus_write(A_STAT, 16'h0002);
    bus_read(A_STAT, d);
    chk("R9 overrun cleared", 32'(d[1]), 32'd0);
    bus_write(A_CTL, ctl(1, 1, 0, 0, 0, 0, 4'd0));
    bus_read(A_RX, d);
    chk("R9 overwritten by later word", 32'(d), 32'h96);
  endtask

  task automatic t_power_off();
    logic [15:0] d;
    bus_write(A_CTL, ctl(1, 1, 1, 0, 0, 0, 4'd0));
    bus_read(A_RX, d);
    repeat (20) @(negedge clk);
    bus_write(A_CTL, ctl(0, 1, 1, 0, 0, 0, 4'd0));
    @(negedge clk);
    chk("R1 idle level after power off", 32'(sclk_o), 32'd0);
    bus_read(A_STAT, d);
    chk("R1 busy dropped", 32'(d[0]), 32'd0);
    quiet(100, "R1 powered down");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_unpowered();
    t_no_rxen();
    t_msb_continuous();
    one_shot(ctl(1, 1, 1, 1, 1, 1, 4'd4), 16'h09C3, 12, "R4 R6 lsb 12-bit");
    one_shot(ctl(1, 1, 1, 0, 1, 0, 4'd15), 16'hBEEF, 16, "R6 clamp 16-bit");
    one_shot(ctl(1, 1, 1, 0, 0, 1, 4'd3), 16'h05A6, 11, "R5 trailing 11-bit");
    one_shot(ctl(1, 1, 1, 1, 0, 0, 4'd0), 16'h00B1, 8, "R4 lsb 8-bit");
    t_scan_end();
    t_overrun();
    t_power_off();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule